// File: doc/BRIEF.md
# Byte-Framed Serial Word Transmitter

This host-side block writes 22-bit control words into a frequency synthesizer over a three-wire port: a serial clock, a data line and a latch enable. A word comes in through a valid/ready handshake. The block adds two zero bits at the front of the word to make a 24-bit frame. It then lowers latch enable and shifts the frame out as three back-to-back 8-bit bytes, MSB first. The serial clock idles low. Data changes only while the clock is low and is sampled by the target on rising edges. After the third byte, the clock returns low and latch enable goes high, which commits the word in the target.

A programmable divider sets the serial clock from the system clock: every serial clock half-period lasts `div_half + 1` system cycles. At power-up the target needs four words before its outputs come alive. A pulse on `init_start` sends these four words from a flattened input table in a fixed order and then raises a one-cycle `init_done` pulse.

The controller has six states. IDLE leaves latch enable high and offers ready. SETUP lowers latch enable and presents the first bit. CLK_HI and CLK_LO form the two halves of each serial bit. TAIL drops the clock after the last bit. HOLD keeps latch enable high for one full serial period. The transitions are as follows:
- `accept` (IDLE to SETUP) starts a frame.
- `first_rise` (SETUP to CLK_HI) gives the first rising edge.
- `fall` (CLK_HI to CLK_LO) ends a bit, and `rise` (CLK_LO to CLK_HI) starts the next.
- `last_fall` (CLK_HI to TAIL) follows the 24th bit.
- `commit` (TAIL to HOLD) raises latch enable.
- `chain` (HOLD to SETUP) moves to the next initialization word.
- `release` (HOLD to IDLE) returns to idle.

Top module: `synth_word_tx`

## Requirements
- R1: Reset state: `ser_le` is 1, `ser_clk` is 0, `ser_data` is 0, `word_ready` is 1 and `init_done` is 0.
- R2: A word is taken when `word_valid` and `word_ready` are both high at a clock edge. From that edge until the controller is back in IDLE, `word_ready` stays 0, and a `word_valid` raised during that time causes no frame.
- R3: `ser_le` falls before the first rising edge of `ser_clk` in a frame and stays 0 through all rising edges of that frame.
- R4: Each frame carries exactly 24 rising edges of `ser_clk`, organised as three consecutive bytes of 8 bits with no gap between them.
- R5: The 24 bits sampled on the rising edges are, MSB first, two zero pad bits followed by the 22 word bits from bit 21 down to bit 0.
- R6: `ser_data` does not change while `ser_clk` is high (clock phase zero). The first bit is valid before the first rising edge.
- R7: `ser_clk` is 0 whenever `ser_le` is 1. `ser_le` rises only after `ser_clk` has returned low following the 24th rising edge.
- R8: Every high and low phase of `ser_clk`, and the setup time from the fall of `ser_le` to the first rising edge, lasts exactly `div_half + 1` system clock cycles.
- R9: Between two frames, `ser_le` stays high for at least `2*(div_half + 1)` system clock cycles.
- R10: A pulse on `init_start` in IDLE sends the four words of `init_table` in index order, entry k at bits `[22k+21:22k]`. Index 0 is channel 1 reference, 1 is channel 1 main, 2 is channel 2 reference and 3 is channel 2 main. `word_ready` stays 0 until the sequence ends.
- R11: `init_done` is a single-cycle pulse given once per sequence, after the fourth initialization word has been latched and its latch-enable hold has ended.
- R12: When `init_start` is high, `word_ready` is 0, so a `word_valid` in the same cycle is not taken and its word is never sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_half | input | DIV_W | Serial clock half-period minus one, in system cycles |
| word_data | input | WORD_W | Control word to send |
| word_valid | input | 1 | Word offered |
| word_ready | output | 1 | Block can take a word this cycle |
| init_start | input | 1 | Start the four-word power-up sequence |
| init_table | input | INIT_WORDS*WORD_W | Power-up words, entry k at bits [k*WORD_W +: WORD_W] |
| init_done | output | 1 | One-cycle pulse after the last power-up word |
| ser_clk | output | 1 | Serial clock, idle low |
| ser_data | output | 1 | Serial data, MSB first |
| ser_le | output | 1 | Latch enable, low during a frame |

## Verification
The bench builds the block with `DIV_W = 4`. With that width the whole divider range, from 0 to 15, can be swept, with one frame at each setting, and the bench measures every clock phase against `div_half + 1`. At the fastest setting it sends walking-one patterns across all 22 data bits, together with all-zero and all-one words, back to back. This exposes any bit-order, padding or byte-count slip, and it also checks the latch-enable gap between chained frames. The power-up sequence runs at a middle divider value, with a competing word offered in the same cycle as `init_start`. That run checks the table order, the priority of `init_start` and the single done pulse.

// File: rtl/swt_pkg.sv
package swt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETUP  = 3'd1,
        ST_CLK_HI = 3'd2,
        ST_CLK_LO = 3'd3,
        ST_TAIL   = 3'd4,
        ST_HOLD   = 3'd5
    } swt_state_e;

endpackage

// File: rtl/swt_tick_gen.sv
// Half-period timer: tick fires once every div_half+1 cycles while run is high.
module swt_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_half,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div_half);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/swt_shifter.sv
// Frame shift register, MSB presented on msb.
module swt_shifter #(
    parameter int FRAME_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] load_val,
    input  logic               shift,
    output logic               msb
);

    logic [FRAME_W-1:0] sr;

    assign msb = sr[FRAME_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr <= '0;
        end else if (load) begin
            sr <= load_val;
        end else if (shift) begin
            sr <= {sr[FRAME_W-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/swt_init_seq.sv
// Power-up table walker: entry 0 first, then entries 1..N-1 on advance.
module swt_init_seq #(
    parameter int WORD_W  = 22,
    parameter int N_WORDS = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic                      advance,
    input  logic [N_WORDS*WORD_W-1:0] table_flat,
    output logic [WORD_W-1:0]         first_word,
    output logic [WORD_W-1:0]         next_word,
    output logic                      last
);

    localparam int IDX_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;

    logic [WORD_W-1:0] entries [N_WORDS];
    logic [IDX_W-1:0]  idx;
    logic [IDX_W-1:0]  nxt_idx;

    for (genvar g = 0; g < N_WORDS; g++) begin : g_unpack
        assign entries[g] = table_flat[g*WORD_W +: WORD_W];
    end

    assign nxt_idx    = idx + 1'b1;
    assign first_word = entries[0];
    assign next_word  = entries[nxt_idx];
    assign last       = (idx == IDX_W'(N_WORDS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (start) begin
            idx <= '0;
        end else if (advance) begin
            idx <= nxt_idx;
        end
    end

endmodule

// File: rtl/synth_word_tx.sv
module synth_word_tx
    import swt_pkg::*;
#(
    parameter int WORD_W     = 22,
    parameter int BYTE_W     = 8,
    parameter int NUM_BYTES  = 3,
    parameter int DIV_W      = 8,
    parameter int INIT_WORDS = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [DIV_W-1:0]             div_half,
    input  logic [WORD_W-1:0]            word_data,
    input  logic                         word_valid,
    output logic                         word_ready,
    input  logic                         init_start,
    input  logic [INIT_WORDS*WORD_W-1:0] init_table,
    output logic                         init_done,
    output logic                         ser_clk,
    output logic                         ser_data,
    output logic                         ser_le
);

    localparam int FRAME_W    = BYTE_W * NUM_BYTES;
    localparam int PAD_W      = FRAME_W - WORD_W;
    localparam int BIT_IDX_W  = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam int BYTE_IDX_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;

    swt_state_e state, state_nxt;

    logic [BIT_IDX_W-1:0]  bit_idx;
    logic [BYTE_IDX_W-1:0] byte_idx;
    logic                  hold_ph;
    logic                  in_init;
    logic                  done_q;

    logic                  tick;
    logic                  run;
    logic                  msb;
    logic                  accept_init, accept_word;
    logic                  last_bit, byte_end;
    logic                  hold_end, chain;
    logic                  load, shift;
    logic [WORD_W-1:0]     sel_word;
    logic [FRAME_W-1:0]    load_val;
    logic [WORD_W-1:0]     first_word, next_word;
    logic                  seq_last;

    // ---------------- control decode ----------------
    assign run         = (state != ST_IDLE);
    assign accept_init = (state == ST_IDLE) && init_start;
    assign accept_word = (state == ST_IDLE) && !init_start && word_valid;
    assign byte_end    = (bit_idx == BIT_IDX_W'(BYTE_W - 1));
    assign last_bit    = byte_end && (byte_idx == BYTE_IDX_W'(NUM_BYTES - 1));
    assign hold_end    = (state == ST_HOLD) && tick && hold_ph;
    assign chain       = hold_end && in_init && !seq_last;
    assign load        = accept_init || accept_word || chain;
    assign shift       = (state == ST_CLK_HI) && tick && !last_bit;

    always_comb begin
        if (accept_word) begin
            sel_word = word_data;
        end else if (accept_init) begin
            sel_word = first_word;
        end else begin
            sel_word = next_word;
        end
    end

    assign load_val = {{PAD_W{1'b0}}, sel_word};

    // ---------------- sub-blocks ----------------
    swt_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .div_half (div_half),
        .tick     (tick)
    );

    swt_shifter #(.FRAME_W(FRAME_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .shift    (shift),
        .msb      (msb)
    );

    swt_init_seq #(.WORD_W(WORD_W), .N_WORDS(INIT_WORDS)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (accept_init),
        .advance    (chain),
        .table_flat (init_table),
        .first_word (first_word),
        .next_word  (next_word),
        .last       (seq_last)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (accept_init || accept_word) state_nxt = ST_SETUP;    // accept
            end
            ST_SETUP: begin
                if (tick) state_nxt = ST_CLK_HI;                         // first_rise
            end
            ST_CLK_HI: begin
                if (tick) state_nxt = last_bit ? ST_TAIL : ST_CLK_LO;    // last_fall / fall
            end
            ST_CLK_LO: begin
                if (tick) state_nxt = ST_CLK_HI;                         // rise
            end
            ST_TAIL: begin
                if (tick) state_nxt = ST_HOLD;                           // commit
            end
            ST_HOLD: begin
                if (hold_end) state_nxt = chain ? ST_SETUP : ST_IDLE;    // chain / release
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // ---------------- frame counters and flags ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_idx  <= '0;
            byte_idx <= '0;
            hold_ph  <= 1'b0;
            in_init  <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            if (load) begin
                bit_idx  <= '0;
                byte_idx <= '0;
            end else if (shift) begin
                if (byte_end) begin
                    bit_idx  <= '0;
                    byte_idx <= byte_idx + 1'b1;
                end else begin
                    bit_idx <= bit_idx + 1'b1;
                end
            end

            if (state != ST_HOLD) begin
                hold_ph <= 1'b0;
            end else if (tick) begin
                hold_ph <= ~hold_ph;
            end

            if (accept_init) begin
                in_init <= 1'b1;
            end else if (hold_end && !chain) begin
                in_init <= 1'b0;
            end

            done_q <= hold_end && in_init && seq_last;
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        ser_clk    = 1'b0;
        ser_le     = 1'b1;
        ser_data   = 1'b0;
        word_ready = 1'b0;
        unique case (state)
            ST_IDLE: begin
                word_ready = !init_start;
            end
            ST_SETUP, ST_CLK_LO, ST_TAIL: begin
                ser_le   = 1'b0;
                ser_data = msb;
            end
            ST_CLK_HI: begin
                ser_le   = 1'b0;
                ser_clk  = 1'b1;
                ser_data = msb;
            end
            ST_HOLD: begin
                ser_le = 1'b1;
            end
            default: begin
                ser_le = 1'b1;
            end
        endcase
    end

    assign init_done = done_q;

endmodule

// File: rtl/swt_checker.sv
module swt_checker #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DIV_W-1:0] div_half,
    input logic             word_ready,
    input logic             init_start,
    input logic             init_done,
    input logic             ser_clk,
    input logic             ser_data,
    input logic             ser_le
);

    logic             clk_q;
    logic             le_q;
    logic [15:0]      gap;
    logic             seen_rise;
    logic [DIV_W-1:0] div_at_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_q       <= 1'b0;
            le_q        <= 1'b1;
            gap         <= '0;
            seen_rise   <= 1'b0;
            div_at_rise <= '0;
        end else begin
            clk_q <= ser_clk;
            le_q  <= ser_le;
            if ((ser_clk != clk_q) || (ser_le != le_q)) begin
                gap <= '0;
            end else if (gap != 16'hFFFF) begin
                gap <= gap + 1'b1;
            end
            if (ser_le && !le_q) begin
                seen_rise   <= 1'b1;
                div_at_rise <= div_half;
            end
        end
    end

    p_ready_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_le |-> !word_ready);

    p_data_still_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

    p_clk_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ser_le |-> !ser_clk);

    p_half_period_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk != clk_q) |-> (int'(gap) == int'(div_half)));

    p_le_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (le_q && !ser_le && seen_rise) |-> (int'(gap) >= 2 * int'(div_at_rise) + 1));

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> !init_done);

    p_init_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        init_start |-> !word_ready);

endmodule

bind synth_word_tx swt_checker #(.DIV_W(DIV_W)) u_swt_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .div_half   (div_half),
    .word_ready (word_ready),
    .init_start (init_start),
    .init_done  (init_done),
    .ser_clk    (ser_clk),
    .ser_data   (ser_data),
    .ser_le     (ser_le)
);

// File: tb/synth_word_tx_bench.sv
module synth_word_tx_bench;

    localparam int WORD_W = 22;
    localparam int DIV_W  = 4;
    localparam int NINIT  = 4;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic [DIV_W-1:0]         div_half = '0;
    logic [WORD_W-1:0]        word_data = '0;
    logic                     word_valid = 1'b0;
    logic                     word_ready;
    logic                     init_start = 1'b0;
    logic [NINIT*WORD_W-1:0]  init_table;
    logic                     init_done;
    logic                     ser_clk, ser_data, ser_le;

    localparam logic [WORD_W-1:0] T0 = 22'h3A5C1F;
    localparam logic [WORD_W-1:0] T1 = 22'h01B2C3;
    localparam logic [WORD_W-1:0] T2 = 22'h2F0F0E;
    localparam logic [WORD_W-1:0] T3 = 22'h155AA9;
    assign init_table = {T3, T2, T1, T0};

    always #4 clk = ~clk;

    synth_word_tx #(.DIV_W(DIV_W)) u_synth_word_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .div_half   (div_half),
        .word_data  (word_data),
        .word_valid (word_valid),
        .word_ready (word_ready),
        .init_start (init_start),
        .init_table (init_table),
        .init_done  (init_done),
        .ser_clk    (ser_clk),
        .ser_data   (ser_data),
        .ser_le     (ser_le)
    );

    int checks = 0;
    int errors = 0;
    logic [WORD_W-1:0] expq [0:127];
    int wr = 0;
    int rd = 0;
    int frames = 0;
    int done_cnt = 0;
    int cyc = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // ---------------- port monitor ----------------
    logic        pc = 1'b0, ple = 1'b1, pd = 1'b0, d_rise = 1'b0;
    logic [23:0] frame = '0;
    int          bits = 0;
    int          gap = 0;
    bit          had_rise = 0;
    int          div_rise = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            gap++;
            if (ser_clk != pc) begin
                chk(gap == int'(div_half) + 1, "R8 half period", gap, int'(div_half) + 1);
                if (ser_clk) begin
                    chk(!ser_le, "R3 le low at rise", ser_le, 0);
                    frame  = {frame[22:0], ser_data};
                    bits++;
                    d_rise = ser_data;
                end else begin
                    chk(pd == d_rise, "R6 data held while clock high", pd, d_rise);
                end
            end
            if (ser_le && !ple) begin
                chk(!ser_clk, "R7 clock low at latch", ser_clk, 0);
                chk(bits == 24, "R4 rising edges per frame", bits, 24);
                chk(frame[23:22] == 2'b00, "R5 pad bits", frame[23:22], 0);
                if (rd < wr) begin
                    chk(frame[21:0] == expq[rd], "R5 frame content", frame[21:0], expq[rd]);
                    rd++;
                end else begin
                    chk(0, "R2 unexpected frame", frame[21:0], 0);
                end
                frames++;
                bits     = 0;
                had_rise = 1;
                div_rise = int'(div_half);
            end
            if (!ser_le && ple) begin
                if (had_rise)
                    chk(gap >= 2 * (div_rise + 1), "R9 latch high gap", gap, 2 * (div_rise + 1));
                bits = 0;
            end
            if ((ser_clk != pc) || (ser_le != ple)) gap = 0;
            if (init_done) done_cnt++;
            pc  = ser_clk;
            ple = ser_le;
            pd  = ser_data;
        end
    end

    // ---------------- watchdog ----------------
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            chk(0, "watchdog", cyc, 150000);
            finish_run();
        end
    end

    task automatic send(input logic [WORD_W-1:0] w);
        @(negedge clk);
        word_valid = 1'b1;
        word_data  = w;
        #1;
        while (!word_ready) begin
            @(negedge clk);
            #1;
        end
        expq[wr] = w;
        wr++;
        @(negedge clk);
        word_valid = 1'b0;
        #1;
        chk(!word_ready, "R2 ready low after accept", word_ready, 0);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        #1;
        while (!(rd == wr && ser_le && word_ready)) begin
            @(negedge clk);
            #1;
        end
    endtask

    initial begin
        // R1: reset values
        repeat (3) @(negedge clk);
        chk(ser_le == 1'b1, "R1 le", ser_le, 1);
        chk(ser_clk == 1'b0, "R1 clk", ser_clk, 0);
        chk(ser_data == 1'b0, "R1 data", ser_data, 0);
        chk(word_ready == 1'b1, "R1 ready", word_ready, 1);
        chk(init_done == 1'b0, "R1 done", init_done, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R8: sweep every divider setting
        for (int d = 0; d < 16; d++) begin
            div_half = DIV_W'(d);
            send(WORD_W'(22'h2AAAAA ^ (d * 22'h01F3B7)));
            wait_idle();
        end

        // R5/R9: walking ones and extremes, back to back at the fastest divider
        div_half = '0;
        for (int b = 0; b < WORD_W; b++) send(WORD_W'(1) << b);
        send('0);
        send('1);
        wait_idle();
        chk(frames == 16 + WORD_W + 2, "R4 frame count", frames, 16 + WORD_W + 2);

        // R2: valid raised while a frame is in flight is not taken
        div_half = DIV_W'(1);
        send(22'h0C3A51);
        @(negedge clk);
        word_valid = 1'b1;
        word_data  = 22'h3FFF00;
        while (!ser_le) @(negedge clk);
        word_valid = 1'b0;
        wait_idle();
        repeat (40) @(negedge clk);
        chk(frames == 16 + WORD_W + 3, "R2 stalled valid ignored", frames, 16 + WORD_W + 3);

        // R10/R11/R12: power-up sequence with a competing word
        div_half = DIV_W'(2);
        @(negedge clk);
        init_start = 1'b1;
        word_valid = 1'b1;
        word_data  = 22'h123456;
        #1;
        chk(!word_ready, "R12 init_start masks ready", word_ready, 0);
        expq[wr] = T0; wr++;
        expq[wr] = T1; wr++;
        expq[wr] = T2; wr++;
        expq[wr] = T3; wr++;
        @(negedge clk);
        init_start = 1'b0;
        word_valid = 1'b0;
        begin
            bit ready_seen = 0;
            while (done_cnt == 0) begin
                @(negedge clk);
                #1;
                if (word_ready && done_cnt == 0) ready_seen = 1;
            end
            chk(!ready_seen, "R10 ready low during init", ready_seen, 0);
        end
        chk(rd == wr, "R11 all four words latched before done", rd, wr);
        wait_idle();
        repeat (40) @(negedge clk);
        chk(done_cnt == 1, "R11 single done pulse", done_cnt, 1);
        chk(frames == 16 + WORD_W + 7, "R12 competing word never sent", frames, 16 + WORD_W + 7);

        // normal operation resumes after the sequence
        send(22'h2B1D07);
        wait_idle();
        chk(frames == 16 + WORD_W + 8, "R2 word after init", frames, 16 + WORD_W + 8);

        finish_run();
    end

endmodule